// File: doc/BRIEF.md
# Framed Serial Word Transmitter with Defined Underflow

This block takes data words from a processor or DMA engine into a one-word holding register. At the start of each frame it moves the held word into a shift register and sends it out most-significant bit first. A bit clock and a frame-sync pulse, both made inside the block, go out with the data. Frame timing comes from one of two sources. In periodic mode a free-running frame counter starts a new frame every N bit clocks. In copy-driven mode a frame starts only when a fresh word is waiting to be copied.

The block defines what happens when software or DMA falls behind. In periodic mode the frame cadence never changes. Each frame with no fresh word sends the last held word again. In copy-driven mode the line goes quiet and no frame sync is produced until a new word arrives. An active-low empty flag shows when the transmitter has run dry. A one-cycle ready pulse, raised each time a fresh word is taken from the holding register, can serve as a DMA request. If a word is written over one that has not yet been sent, a sticky flag records it.

The frame state machine has three states. ST_IDLE waits for the first frame, or for data in copy-driven mode. ST_SHIFT sends the word bits. ST_PAD fills the rest of the frame with zeros. The transitions are:
- load: from ST_IDLE, ST_SHIFT or ST_PAD into ST_SHIFT at a frame start.
- advance: a stay in ST_SHIFT that moves to the next bit.
- word done: from ST_SHIFT to ST_PAD after the last word bit, when the frame is longer than the word.
- halt: from ST_SHIFT or ST_PAD back to ST_IDLE at frame end in copy-driven mode when no word is waiting.

Top module: `serial_audio_tx`

## Requirements
- R1: After reset the empty flag `empty_n_o` reads 0. `fsync_o`, `sdata_o`, `xrdy_o` and `ovf_o` also read 0.
- R2: The bit clock period is BCLK_DIV system clocks: low for the first half, high for the second. Data changes only where the bit clock falls. Each frame carries WORD_W bits, most-significant bit first. `fsync_o` is high during the first bit slot of the frame.
- R3: A frame lasts max(`frame_len_i`, WORD_W) bit clocks. The bit slots after the word drive `sdata_o` to 0, and so does the idle line.
- R4: `empty_n_o` drops to 0 when the last word bit has gone out and the holding register has no fresh word. It returns to 1 only when a fresh word is copied into the shift register.
- R5: In periodic mode (`copy_fs_mode_i`=0), a frame that starts with no fresh word sends the previously held word again. This repeats until a new word is written.
- R6: In periodic mode, frame syncs come every frame length whether or not data was written.
- R7: In copy-driven mode (`copy_fs_mode_i`=1), a frame starts at the first bit boundary after a word is waiting, or at frame end when the next word is already waiting. While no word is waiting, no frame sync is produced.
- R8: `xrdy_o` is a one-cycle pulse. It fires once for each fresh word copied out of the holding register, and not for a repeated word.
- R9: Writing while the holding register still holds an unsent word replaces that word and sets `ovf_o`. `ovf_o` stays set until `ovf_clr_i` is pulsed, and the clear wins over a simultaneous set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Write strobe for the holding register |
| wr_data_i | input | WORD_W | Word to transmit |
| copy_fs_mode_i | input | 1 | 1: frame sync per copy; 0: periodic frame sync (held stable out of reset) |
| frame_len_i | input | PERIOD_W | Frame length in bit clocks (clamped to WORD_W) |
| ovf_clr_i | input | 1 | Clears the overwrite flag |
| bclk_o | output | 1 | Bit clock |
| fsync_o | output | 1 | Frame sync, high during the first bit slot |
| sdata_o | output | 1 | Serial data, MSB first |
| xrdy_o | output | 1 | One-cycle transmit-ready / DMA request pulse |
| empty_n_o | output | 1 | Active-low transmitter-empty flag |
| ovf_o | output | 1 | Sticky holding-register overwrite flag |

## Verification
The bench builds the block with WORD_W=8, BCLK_DIV=4 and PERIOD_W=5. With these values a whole frame takes a few dozen clocks, so runs of stale repeats, stalled copy-driven intervals and back-to-back frames all fit in short scenarios. The 5-bit frame length lets the bench use frames longer than the word (10, 12, 20), which exercises the zero-padding state. It also lets the bench use a length of 3, which must clamp up to the word length. The two-clock high and low halves of the bit clock leave room to place writes between bit boundaries, and to observe the empty flag and the overwrite flag before the next frame starts.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_PAD   = 2'd2
    } tx_state_e;
endpackage

// File: rtl/sertx_bitclk.sv
module sertx_bitclk #(
    parameter int BCLK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic bit_tick_o,
    output logic bclk_o
);
    localparam int DW = (BCLK_DIV > 2) ? $clog2(BCLK_DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(BCLK_DIV - 1);
    localparam logic [DW-1:0] HALF = DW'(BCLK_DIV / 2);
    localparam logic [DW-1:0] ONE  = DW'(1);

    logic [DW-1:0] div_q;

    always_ff @(posedge clk) begin
        if (!rst_n)             div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else                    div_q <= div_q + ONE;
    end

    // bit boundary at the last divider count; bit clock falls there
    assign bit_tick_o = (div_q == LAST);
    assign bclk_o     = (div_q >= HALF);
endmodule

// File: rtl/sertx_hold.sv
module sertx_hold #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [WORD_W-1:0] wr_data_i,
    input  logic              consume_i,
    input  logic              ovf_clr_i,
    output logic [WORD_W-1:0] hold_word_o,
    output logic              hold_full_o,
    output logic              xrdy_o,
    output logic              ovf_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_word_o <= '0;
            hold_full_o <= 1'b0;
            xrdy_o      <= 1'b0;
            ovf_o       <= 1'b0;
        end else begin
            xrdy_o <= consume_i;
            if (wr_en_i) begin
                hold_word_o <= wr_data_i;
                hold_full_o <= 1'b1;
            end else if (consume_i) begin
                hold_full_o <= 1'b0;
            end
            if (ovf_clr_i)
                ovf_o <= 1'b0;
            else if (wr_en_i && hold_full_o && !consume_i)
                ovf_o <= 1'b1;
        end
    end
endmodule

// File: rtl/sertx_frame_fsm.sv
module sertx_frame_fsm
    import sertx_pkg::*;
#(
    parameter int WORD_W   = 16,
    parameter int PERIOD_W = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_tick_i,
    input  logic                copy_mode_i,
    input  logic [PERIOD_W-1:0] frame_len_i,
    input  logic [WORD_W-1:0]   hold_word_i,
    input  logic                hold_full_i,
    output logic                consume_o,
    output logic                sdata_o,
    output logic                fsync_o,
    output logic                empty_n_o
);
    localparam int CW = (PERIOD_W > $clog2(WORD_W + 1)) ? PERIOD_W : $clog2(WORD_W + 1);
    localparam logic [CW-1:0] ONE       = CW'(1);
    localparam logic [CW-1:0] WORD_LAST = CW'(WORD_W - 1);
    localparam logic [CW-1:0] WORD_LEN  = CW'(WORD_W);

    tx_state_e         state_q, state_d;
    logic [CW-1:0]     slot_q, slot_d;
    logic [WORD_W-1:0] xsr_q, xsr_d;
    logic              empty_q, empty_d;
    logic [CW-1:0]     len_ext, frame_last;
    logic              start_ok, frame_end, load, halt;

    always_comb begin
        len_ext    = CW'(frame_len_i);
        frame_last = (len_ext < WORD_LEN) ? WORD_LAST : (len_ext - ONE);
        frame_end  = (slot_q == frame_last);
        start_ok   = copy_mode_i ? hold_full_i : 1'b1;
    end

    // next-state and datapath
    always_comb begin
        state_d   = state_q;
        slot_d    = slot_q;
        xsr_d     = xsr_q;
        empty_d   = empty_q;
        consume_o = 1'b0;
        load      = 1'b0;
        halt      = 1'b0;
        if (bit_tick_i) begin
            unique case (state_q)
                ST_IDLE: load = start_ok;
                ST_SHIFT: begin
                    if (frame_end) begin
                        load = start_ok;
                        halt = !start_ok;
                    end else if (slot_q == WORD_LAST) begin
                        state_d = ST_PAD;
                        slot_d  = slot_q + ONE;
                    end else begin
                        slot_d = slot_q + ONE;
                        xsr_d  = {xsr_q[WORD_W-2:0], 1'b0};
                    end
                end
                ST_PAD: begin
                    if (frame_end) begin
                        load = start_ok;
                        halt = !start_ok;
                    end else begin
                        slot_d = slot_q + ONE;
                    end
                end
                default: halt = 1'b1;
            endcase
            if (state_q == ST_SHIFT && slot_q == WORD_LAST && !hold_full_i)
                empty_d = 1'b0;
            if (load) begin
                state_d = ST_SHIFT;
                slot_d  = '0;
                xsr_d   = hold_word_i;   // fresh word, or the stale one again
                if (hold_full_i) begin
                    consume_o = 1'b1;
                    empty_d   = 1'b1;
                end
            end
            if (halt) begin
                state_d = ST_IDLE;
                slot_d  = '0;
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            slot_q  <= '0;
            xsr_q   <= '0;
            empty_q <= 1'b0;
        end else begin
            state_q <= state_d;
            slot_q  <= slot_d;
            xsr_q   <= xsr_d;
            empty_q <= empty_d;
        end
    end

    // outputs
    always_comb begin
        sdata_o   = (state_q == ST_SHIFT) ? xsr_q[WORD_W-1] : 1'b0;
        fsync_o   = (state_q == ST_SHIFT) && (slot_q == '0);
        empty_n_o = empty_q;
    end
endmodule

// File: rtl/serial_audio_tx.sv
module serial_audio_tx #(
    parameter int WORD_W   = 16,
    parameter int BCLK_DIV = 4,
    parameter int PERIOD_W = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en_i,
    input  logic [WORD_W-1:0]   wr_data_i,
    input  logic                copy_fs_mode_i,
    input  logic [PERIOD_W-1:0] frame_len_i,
    input  logic                ovf_clr_i,
    output logic                bclk_o,
    output logic                fsync_o,
    output logic                sdata_o,
    output logic                xrdy_o,
    output logic                empty_n_o,
    output logic                ovf_o
);
    logic              bit_tick;
    logic              consume;
    logic              hold_full;
    logic [WORD_W-1:0] hold_word;

    sertx_bitclk #(.BCLK_DIV(BCLK_DIV)) i_bitclk (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_tick_o(bit_tick),
        .bclk_o    (bclk_o)
    );

    sertx_hold #(.WORD_W(WORD_W)) i_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en_i),
        .wr_data_i  (wr_data_i),
        .consume_i  (consume),
        .ovf_clr_i  (ovf_clr_i),
        .hold_word_o(hold_word),
        .hold_full_o(hold_full),
        .xrdy_o     (xrdy_o),
        .ovf_o      (ovf_o)
    );

    sertx_frame_fsm #(.WORD_W(WORD_W), .PERIOD_W(PERIOD_W)) i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_tick_i (bit_tick),
        .copy_mode_i(copy_fs_mode_i),
        .frame_len_i(frame_len_i),
        .hold_word_i(hold_word),
        .hold_full_i(hold_full),
        .consume_o  (consume),
        .sdata_o    (sdata_o),
        .fsync_o    (fsync_o),
        .empty_n_o  (empty_n_o)
    );
endmodule

// File: rtl/serial_audio_tx_chk.sv
module serial_audio_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic copy_fs_mode_i,
    input logic ovf_clr_i,
    input logic fsync_o,
    input logic xrdy_o,
    input logic empty_n_o,
    input logic ovf_o
);
    AST_EMPTY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !$past(rst_n)) |-> !empty_n_o);                 // R1
    AST_EMPTY_RISE_ON_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(empty_n_o) |-> xrdy_o);                             // R4
    AST_COPY_MODE_FS_NEEDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (copy_fs_mode_i && $rose(fsync_o)) |-> xrdy_o);           // R7
    AST_XRDY_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        xrdy_o |=> !xrdy_o);                                      // R8
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !ovf_clr_i) |=> ovf_o);                         // R9
    AST_OVF_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_clr_i |=> !ovf_o);                                    // R9
endmodule

bind serial_audio_tx serial_audio_tx_chk i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .copy_fs_mode_i(copy_fs_mode_i),
    .ovf_clr_i     (ovf_clr_i),
    .fsync_o       (fsync_o),
    .xrdy_o        (xrdy_o),
    .empty_n_o     (empty_n_o),
    .ovf_o         (ovf_o)
);

// File: tb/test_serial_audio_tx.sv
module test_serial_audio_tx;
    localparam int CLK_PERIOD = 10;
    localparam int W    = 8;
    localparam int DIV  = 4;
    localparam int PW   = 5;
    localparam int WDOG = 100000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en_i = 1'b0;
    logic [W-1:0]  wr_data_i = '0;
    logic          copy_fs_mode_i = 1'b0;
    logic [PW-1:0] frame_len_i = PW'(12);
    logic          ovf_clr_i = 1'b0;
    logic          bclk_o, fsync_o, sdata_o, xrdy_o, empty_n_o, ovf_o;

    serial_audio_tx #(.WORD_W(W), .BCLK_DIV(DIV), .PERIOD_W(PW)) i_serial_audio_tx (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
        .copy_fs_mode_i(copy_fs_mode_i), .frame_len_i(frame_len_i), .ovf_clr_i(ovf_clr_i),
        .bclk_o(bclk_o), .fsync_o(fsync_o), .sdata_o(sdata_o), .xrdy_o(xrdy_o),
        .empty_n_o(empty_n_o), .ovf_o(ovf_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int vectors = 0;
    int fails   = 0;
    bit wd_fired = 1'b0;

    // monitor state
    int         cyc, last_rise_cyc, rise_gap;
    int         bit_no, last_fs_bit;
    int         fs_cnt, nfr, xrdy_cnt, pad_err;
    logic       bclk_q;
    bit         collecting;
    int         nbits;
    logic [W-1:0] shreg;
    logic [W-1:0] frames [64];
    int         per      [64];
    logic       fs_empty [64];

    always @(negedge clk) begin
        if (!rst_n) begin
            cyc = 0; last_rise_cyc = 0; rise_gap = 0; bit_no = 0; last_fs_bit = 0;
            fs_cnt = 0; nfr = 0; xrdy_cnt = 0; pad_err = 0; bclk_q = 1'b0;
            collecting = 1'b0; nbits = 0; shreg = '0;
        end else begin
            cyc++;
            if (xrdy_o) xrdy_cnt++;
            if (bclk_o && !bclk_q) begin
                rise_gap = cyc - last_rise_cyc;
                last_rise_cyc = cyc;
                bit_no++;
                if (fsync_o) begin
                    if (fs_cnt < 64) begin
                        per[fs_cnt]      = bit_no - last_fs_bit;
                        fs_empty[fs_cnt] = empty_n_o;
                    end
                    fs_cnt++;
                    last_fs_bit = bit_no;
                    collecting = 1'b1;
                    nbits = 0;
                end
                if (collecting) begin
                    shreg = {shreg[W-2:0], sdata_o};
                    nbits++;
                    if (nbits == W) begin
                        if (nfr < 64) frames[nfr] = shreg;
                        nfr++;
                        collecting = 1'b0;
                    end
                end else if (sdata_o !== 1'b0) begin
                    pad_err++;
                end
            end
            bclk_q = bclk_o;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic apply_reset(input logic mode, input int len);
        rst_n = 1'b0;
        copy_fs_mode_i = mode;
        frame_len_i = PW'(len);
        wr_en_i = 1'b0;
        ovf_clr_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic write_word(input logic [W-1:0] d);
        wr_en_i = 1'b1;
        wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic wait_frames(input int n);
        int target = nfr + n;
        while (nfr < target) @(negedge clk);
    endtask

    task automatic t_reset_state();
        apply_reset(1'b0, 12);
        check(empty_n_o == 1'b0, "R1 empty_n after reset", empty_n_o, 0);
        check(fsync_o == 1'b0 && sdata_o == 1'b0, "R1 fsync/sdata after reset",
              {fsync_o, sdata_o}, 0);
        check(xrdy_o == 1'b0 && ovf_o == 1'b0, "R1 xrdy/ovf after reset", {xrdy_o, ovf_o}, 0);
    endtask

    task automatic t_gen_underflow();
        apply_reset(1'b0, 12);
        write_word(8'hA5);
        wait_frames(4);
        check(frames[0] == 8'hA5, "R2 first frame word MSB first", frames[0], 8'hA5);
        check(rise_gap == DIV, "R2 bit clock period", rise_gap, DIV);
        check(fs_empty[0] == 1'b1, "R4 empty_n high on fresh copy", fs_empty[0], 1);
        check(fs_empty[1] == 1'b0, "R4 empty_n low in underflow", fs_empty[1], 0);
        for (int k = 1; k < 4; k++)
            check(frames[k] == 8'hA5, "R5 stale word resent", frames[k], 8'hA5);
        for (int k = 1; k < 4; k++)
            check(per[k] == 12, "R6 periodic frame sync spacing", per[k], 12);
        check(xrdy_cnt == 1, "R8 one ready pulse per fresh word", xrdy_cnt, 1);
        write_word(8'h3C);
        wait_frames(2);
        check(frames[4] == 8'h3C, "R5 new word ends underflow", frames[4], 8'h3C);
        check(fs_empty[4] == 1'b1, "R4 empty_n returns on copy", fs_empty[4], 1);
        check(frames[5] == 8'h3C, "R5 new word then resent", frames[5], 8'h3C);
        check(per[5] == 12, "R6 period unchanged after write", per[5], 12);
        check(xrdy_cnt == 2, "R8 no pulse on stale resend", xrdy_cnt, 2);
        check(pad_err == 0, "R3 pad slots drive zero", pad_err, 0);
    endtask

    task automatic t_len_clamp();
        apply_reset(1'b0, 3);
        write_word(8'hC3);
        wait_frames(3);
        check(frames[0] == 8'hC3, "R2 word with clamped frame", frames[0], 8'hC3);
        check(per[1] == W && per[2] == W, "R3 short length clamps to word", per[1], W);
    endtask

    task automatic t_copy_mode();
        int n;
        apply_reset(1'b1, 10);
        repeat (200) @(negedge clk);
        check(fs_cnt == 0, "R7 no frame sync before data", fs_cnt, 0);
        check(empty_n_o == 1'b0, "R4 empty while idle", empty_n_o, 0);
        write_word(8'h81);
        wait_frames(1);
        check(frames[0] == 8'h81, "R7 copy starts frame", frames[0], 8'h81);
        write_word(8'h42);
        wait_frames(1);
        check(frames[1] == 8'h42, "R7 back-to-back word", frames[1], 8'h42);
        check(per[1] == 10, "R7 back-to-back spacing", per[1], 10);
        n = fs_cnt;
        repeat (200) @(negedge clk);
        check(fs_cnt == n, "R7 frame sync stops with no data", fs_cnt, n);
        check(empty_n_o == 1'b0, "R4 empty after last word", empty_n_o, 0);
        check(pad_err == 0, "R3 idle line zero", pad_err, 0);
        write_word(8'h7E);
        wait_frames(1);
        check(frames[2] == 8'h7E, "R7 restart after stall", frames[2], 8'h7E);
        check(xrdy_cnt == 3, "R8 ready per copy", xrdy_cnt, 3);
    endtask

    task automatic t_overwrite();
        apply_reset(1'b0, 20);
        write_word(8'h11);
        wait_frames(1);
        check(ovf_o == 1'b0, "R9 no overwrite on normal write", ovf_o, 0);
        write_word(8'h22);
        write_word(8'h33);
        check(ovf_o == 1'b1, "R9 overwrite flagged", ovf_o, 1);
        wait_frames(1);
        check(frames[1] == 8'h33, "R9 later word wins", frames[1], 8'h33);
        check(ovf_o == 1'b1, "R9 flag sticky", ovf_o, 1);
        check(xrdy_cnt == 2, "R8 overwritten word not counted", xrdy_cnt, 2);
        ovf_clr_i = 1'b1;
        @(negedge clk);
        ovf_clr_i = 1'b0;
        check(ovf_o == 1'b0, "R9 flag cleared", ovf_o, 0);
    endtask

    initial begin
        fork
            begin
                t_reset_state();
                t_gen_underflow();
                t_len_clamp();
                t_copy_mode();
                t_overwrite();
            end
            begin
                repeat (WDOG) @(posedge clk);
                wd_fired = 1'b1;
            end
        join_any
        disable fork;
        if (wd_fired) begin
            vectors++;
            fails++;
            $display("FAIL watchdog: actual=%0d expected=0 cycles over limit", WDOG);
        end
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule